// File: doc/BRIEF.md
# Far-end alarm code transmitter

This block sends a 16-bit far-end alarm and control code over a framed serial link. The framer gives one code-bit slot per outgoing frame. It raises `slot_stb` for one clock to mark that slot and takes `tx_bit` during that cycle. When software starts a transmission, the block sends the stored code most-significant bit first. It repeats the code a fixed number of times back to back, one bit per slot. After the last repetition it flags completion and can interrupt the host.

Whenever no transmission is running, every slot carries a 1. The far end reads this as the idle code, and it continues for as long as software leaves the block alone. Software uses a byte-wide bus with one write strobe and one read strobe. It reaches an 8-bit control/status register and the two bytes of the code register.

Top module: `farend_code_tx`

## Requirements
- R1: After reset the control/status register (address 0) reads 0x00, `irq` is 0 and `tx_bit` is 1.
- R2: The register fields are as follows:
  - Address 0 holds the control/status register: bit 0 busy (read-only), bit 1 go (write-only, always reads 0), bit 2 enable, bit 3 interrupt status (read-only), bit 4 interrupt enable. Bits 7..5 read 0.
  - Address 1 holds the code low byte and address 2 holds the code high byte. Both read back what was written.
  - Writes to the read-only bits have no effect.
- R3: A write to address 0 with bit 1 and bit 2 both 1 starts a transmission when busy is 0. A go written with bit 2 at 0 starts nothing.
- R4: During a transmission, each `slot_stb` consumes one code bit, sent MSB first. The 16-bit code is sent REPS times back to back (160 slots with REPS=10). `tx_bit` equals the current code bit in the cycle the strobe is high.
- R5: Busy reads 1 from the cycle after the starting write. It drops to 0 after the strobe that consumes the last bit of the last repetition.
- R6: On completion, interrupt status is set. `irq` is 1 exactly while both interrupt status and interrupt enable are 1.
- R7: A read of address 0 clears interrupt status and with it `irq`. A completion in the same cycle takes precedence.
- R8: While busy is 0, `tx_bit` is 1, and this holds indefinitely.
- R9: A go written while busy is 1 is ignored. The sequence in progress continues unchanged.
- R10: The code is captured at start. Code register writes during a transmission do not change the bits sent.
- R11: Writing enable as 0 while busy aborts the transmission. Busy clears, interrupt status is not set, and `tx_bit` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read of address 0 clears interrupt status) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| slot_stb | input | 1 | One-cycle mark of a frame's code-bit slot |
| tx_bit | output | 1 | Bit for the current slot |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with REPS at its default of 10. This lets it follow a complete 160-slot transmission bit by bit. It can then land a go request and a code rewrite exactly at the midpoint of a live sequence, and observe completion with the interrupt enable both set and clear. A short transmission with the distinctive code 0x8001 is cut off after a few slots to reach the abort path.

// File: rtl/farend_code_tx.sv
module farend_code_tx #(
  parameter int REPS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       slot_stb,
  output logic       tx_bit,
  output logic       irq
);
  localparam int CODE_W = 16;
  localparam int IDX_W  = $clog2(CODE_W);
  localparam int REP_W  = $clog2(REPS + 1);

  logic [CODE_W-1:0] code_q, shreg;
  logic [IDX_W-1:0]  idx;
  logic [REP_W-1:0]  rep;
  logic              busy, en, ien, ists;

  wire wr_ctrl  = bus_wr && bus_addr == 2'd0;
  wire rd_ctrl  = bus_rd && bus_addr == 2'd0;
  wire start    = wr_ctrl && bus_wdata[1] && bus_wdata[2] && !busy;
  wire abort    = wr_ctrl && !bus_wdata[2] && busy;
  wire step     = busy && slot_stb && !abort;
  wire last_bit = idx == IDX_W'(CODE_W - 1);
  wire last_rep = rep == REP_W'(REPS - 1);
  wire done     = step && last_bit && last_rep;

  assign tx_bit = busy ? shreg[CODE_W-1] : 1'b1;
  assign irq    = ists && ien;

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {3'b000, ien, ists, en, 1'b0, busy};
      2'd1:    bus_rdata = code_q[7:0];
      2'd2:    bus_rdata = code_q[15:8];
      default: bus_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      shreg  <= '0;
      idx    <= '0;
      rep    <= '0;
      busy   <= 1'b0;
      en     <= 1'b0;
      ien    <= 1'b0;
      ists   <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == 2'd1) code_q[7:0]  <= bus_wdata;
      if (bus_wr && bus_addr == 2'd2) code_q[15:8] <= bus_wdata;
      if (wr_ctrl) begin
        en  <= bus_wdata[2];
        ien <= bus_wdata[4];
      end
      if (abort)      busy <= 1'b0;
      else if (start) busy <= 1'b1;
      else if (done)  busy <= 1'b0;
      if (start) begin
        shreg <= code_q;
        idx   <= '0;
        rep   <= '0;
      end else if (step) begin
        shreg <= {shreg[CODE_W-2:0], shreg[CODE_W-1]};
        idx   <= idx + 1'b1;
        if (last_bit) rep <= rep + 1'b1;
      end
      if (done)         ists <= 1'b1;
      else if (rd_ctrl) ists <= 1'b0;
    end
  end

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && idx == '0 && rep == '0);
  p_noen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !bus_wdata[2] && !busy) |=> !busy);
  p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy && ists);
  p_busy_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(slot_stb) || $past(wr_ctrl));
  p_rdclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && !done) |=> !ists && !irq);
  p_go_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_ctrl && bus_wdata[2] && !slot_stb) |=> busy && $stable(idx) && $stable(rep));
  p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !slot_stb && !wr_ctrl) |=> $stable(shreg));
  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !ists) |=> !busy && !ists && tx_bit);
endmodule

// File: tb/sim_farend_code_tx.sv
module sim_farend_code_tx;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0, slot_stb = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic tx_bit, irq;
  int checks = 0, fails = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  farend_code_tx u0 (.clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata,
                     .bus_rdata, .slot_stb, .tx_bit, .irq);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic slot(output logic b);
    @(negedge clk); slot_stb = 1; #1 b = tx_bit;
    @(negedge clk); slot_stb = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(0, d);
    chk("R1 status", d, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 tx_bit", tx_bit, 1);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(1, 8'hC3); wr(2, 8'hA5);
    rd(1, d); chk("R2 code lo", d, 8'hC3);
    rd(2, d); chk("R2 code hi", d, 8'hA5);
    wr(0, 8'hF9);
    rd(0, d); chk("R2 ro bits ignored", d, 8'h10);
    wr(0, 8'h14);
    rd(0, d); chk("R2 enable+ien", d, 8'h14);
  endtask

  task automatic t_no_enable;
    logic [7:0] d; logic b;
    wr(0, 8'h02);
    rd(0, d); chk("R3 go without enable", d, 8'h00);
    slot(b); chk("R3 idle after ignored go", b, 1);
  endtask

  task automatic t_full;
    logic [7:0] d; logic b;
    logic [15:0] code = 16'hA5C3;
    int bad = 0;
    wr(0, 8'h16);
    rd(0, d); chk("R5 busy after start", d, 8'h15);
    for (int i = 0; i < 160; i++) begin
      if (i == 80) begin
        wr(1, 8'h00); wr(2, 8'h00);
        wr(0, 8'h16);
        rd(0, d); chk("R9 go while busy keeps busy", d, 8'h15);
      end
      if (i == 159) begin
        rd(0, d); chk("R5 busy before last slot", d[0], 1);
      end
      slot(b);
      if (b !== code[15 - (i % 16)]) begin
        bad++;
        chk("R4 R10 bit sequence", b, code[15 - (i % 16)]);
      end
      @(negedge clk);
    end
    chk("R4 mismatched bits", bad, 0);
    chk("R6 irq on completion", irq, 1);
    slot(b); chk("R8 idle after completion", b, 1);
    rd(0, d); chk("R5 R6 status at completion", d, 8'h1C);
    chk("R7 irq cleared by read", irq, 0);
    rd(0, d); chk("R7 status cleared", d, 8'h14);
  endtask

  task automatic t_no_ien;
    logic [7:0] d; logic b;
    int bad = 0;
    wr(0, 8'h06);
    for (int i = 0; i < 160; i++) begin
      slot(b);
      if (b !== 1'b0) begin bad++; chk("R4 zero code bits", b, 0); end
    end
    chk("R4 zero code mismatches", bad, 0);
    chk("R6 no irq without enable", irq, 0);
    for (int i = 0; i < 20; i++) begin
      slot(b);
      if (b !== 1'b1) bad++;
    end
    chk("R8 idle ones continue", bad, 0);
    rd(0, d); chk("R6 status set without ien", d, 8'h0C);
    rd(0, d); chk("R7 cleared after read", d, 8'h04);
  endtask

  task automatic t_abort;
    logic [7:0] d; logic b;
    wr(1, 8'h01); wr(2, 8'h80);
    wr(0, 8'h16);
    slot(b); chk("R4 first bit MSB", b, 1);
    for (int i = 0; i < 4; i++) begin
      slot(b); chk("R4 middle zero bits", b, 0);
    end
    wr(0, 8'h10);
    rd(0, d); chk("R11 aborted status", d, 8'h10);
    chk("R11 no irq on abort", irq, 0);
    slot(b); chk("R11 idle after abort", b, 1);
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_no_enable();
    t_full();
    t_no_ien();
    t_abort();
    finish_run();
  end
endmodule